// File: doc/BRIEF.md
# Masked Breakpoint Address Comparator

This block watches the CPU bus on behalf of an on-chip debug unit. On every cycle that carries a valid access, it compares the access address with a programmed breakpoint address. It then raises a one-cycle registered match pulse on the following clock edge. The compare width follows the access:
- An access inside the paged program window is compared on 20 bits: the 6-bit page value joined with the 14 window offset bits.
- Any other access is compared on the flat 16-bit address.

Two byte-mask controls narrow the compare:
- The upper mask control, with the lower one clear, is an illegal setting. It is overridden to a full compare.
- With only the lower mask set, the low address byte drops out of the compare.
- With both masks set, only the page value is compared. This matches any access to one page.

An optional direction qualifier restricts matches to reads or to writes. A debug-mode flag clears both masks so that the compare is always full.

Top module: `bkpt_addr_match`

## Requirements
- R1: For a paged access (`bus_paged`=1) with a full compare, the block matches when `{bus_page[5:0], bus_addr[13:0]}` equals `{cmp_ext[5:0], cmp_hi[5:0], cmp_lo[7:0]}`. Bits `bus_addr[15:14]` and `cmp_hi[7:6]` take no part in this compare.
- R2: For a non-paged access with a full compare, the block matches when `bus_addr[15:0]` equals `{cmp_hi, cmp_lo}`. The values of `bus_page` and `cmp_ext` have no effect.
- R3: With `mask_hi`=0 and `mask_lo`=0, the compare is full, as in R1 and R2.
- R4: With `mask_hi`=0 and `mask_lo`=1, `bus_addr[7:0]` is excluded from the compare.
  - A paged access matches on page and `bus_addr[13:8]` against `cmp_ext` and `cmp_hi[5:0]`.
  - A non-paged access matches on `bus_addr[15:8]` against `cmp_hi`.
- R5: The setting `mask_hi`=1 with `mask_lo`=0 is illegal. It is treated as a full compare.
- R6: With `mask_hi`=1 and `mask_lo`=1, a paged access matches when `bus_page` equals `cmp_ext`, whatever `bus_addr` holds.
- R7: With `mask_hi`=1 and `mask_lo`=1, a non-paged access never matches.
- R8: With `dir_en`=0, the access direction (`bus_read`) has no effect on the match.
- R9: With `dir_en`=1, only accesses whose `bus_read` equals `dir_read` can match. Here `bus_read`=1 means a read and 0 means a write, so `dir_read`=1 selects reads and `dir_read`=0 selects writes.
- R10: With `dbg_mode`=1, both mask controls are treated as 0, so the compare is always full.
- R11: `hit` is asserted for exactly one cycle, on the clock edge after a qualifying access. It is asserted only if `bus_valid` was 1 for that access. A synchronous `rst` clears `hit` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_addr | input | 16 | CPU access address |
| bus_page | input | 6 | Extended page value of the access |
| bus_paged | input | 1 | Access falls in the paged program window |
| bus_read | input | 1 | 1 = read access, 0 = write access |
| cmp_ext | input | 6 | Breakpoint page value |
| cmp_hi | input | 8 | Breakpoint address high byte |
| cmp_lo | input | 8 | Breakpoint address low byte |
| mask_hi | input | 1 | Upper byte-mask control |
| mask_lo | input | 1 | Lower byte-mask control |
| dir_en | input | 1 | Use the access direction in the match |
| dir_read | input | 1 | Direction to match: 1 = read, 0 = write |
| dbg_mode | input | 1 | Debug mode: forces a full compare |
| hit | output | 1 | Registered one-cycle match pulse |

## Verification
The match is formed combinationally and captured in a single output register. A wrong decoded compare mode, a wrong width selection or a wrong direction qualifier therefore appears on `hit` one clock after the offending access, with no delay or accumulation. The directed scenarios aim at the cases where a fault would stay hidden on ordinary traffic:
- addresses that differ only in the bits one mask setting ignores and another compares;
- page values that differ while the flat address is equal;
- the illegal and debug-forced mask settings.

A sweep over every mask setting, window flag, direction and debug value, checked against a bench model, catches a wrong mode decode on the first access that exposes it.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  // Effective compare mode after mask override rules
  typedef enum logic [1:0] {
    CMP_FULL  = 2'd0,  // every address line compared
    CMP_UPPER = 2'd1,  // low byte excluded
    CMP_PAGE  = 2'd2   // page value only
  } cmp_mode_e;
endpackage

// File: rtl/bkpt_mask_decode.sv
module bkpt_mask_decode
  import bkpt_pkg::*;
(
  input  logic      mask_hi,
  input  logic      mask_lo,
  input  logic      dbg_mode,
  output cmp_mode_e mode
);
  logic eff_hi;
  logic eff_lo;

  // debug mode clears both mask controls
  assign eff_hi = mask_hi & ~dbg_mode;
  assign eff_lo = mask_lo & ~dbg_mode;

  always_comb begin
    unique case ({eff_hi, eff_lo})
      2'b01:   mode = CMP_UPPER;
      2'b11:   mode = CMP_PAGE;
      default: mode = CMP_FULL;  // 00, and illegal 10 folds here
    endcase
  end
endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6,
  parameter int WIN_W  = 14
) (
  input  cmp_mode_e         mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PAGE_W-1:0] bus_page,
  input  logic              bus_paged,
  input  logic [PAGE_W-1:0] cmp_ext,
  input  logic [ADDR_W/2-1:0] cmp_hi,
  input  logic [ADDR_W/2-1:0] cmp_lo,
  output logic              addr_hit
);
  localparam int LO_W    = ADDR_W / 2;
  localparam int WHI_W   = WIN_W - LO_W;  // high-byte bits inside the window

  logic page_eq;
  logic lo_eq;
  logic win_hi_eq;
  logic flat_hi_eq;
  logic paged_hit;
  logic flat_hit;

  assign page_eq    = (bus_page == cmp_ext);
  assign lo_eq      = (bus_addr[LO_W-1:0] == cmp_lo);
  assign win_hi_eq  = (bus_addr[WIN_W-1:LO_W] == cmp_hi[WHI_W-1:0]);
  assign flat_hi_eq = (bus_addr[ADDR_W-1:LO_W] == cmp_hi);

  always_comb begin
    paged_hit = 1'b0;
    flat_hit  = 1'b0;
    unique case (mode)
      CMP_FULL: begin
        paged_hit = page_eq & win_hi_eq & lo_eq;
        flat_hit  = flat_hi_eq & lo_eq;
      end
      CMP_UPPER: begin
        paged_hit = page_eq & win_hi_eq;
        flat_hit  = flat_hi_eq;
      end
      CMP_PAGE: begin
        paged_hit = page_eq;
        flat_hit  = 1'b0;  // page-only never hits a flat access
      end
      default: begin
        paged_hit = 1'b0;
        flat_hit  = 1'b0;
      end
    endcase
  end

  assign addr_hit = bus_paged ? paged_hit : flat_hit;
endmodule

// File: rtl/bkpt_dir_qual.sv
module bkpt_dir_qual (
  input  logic dir_en,
  input  logic dir_read,
  input  logic bus_read,
  output logic dir_ok
);
  assign dir_ok = ~dir_en | ~(dir_read ^ bus_read);
endmodule

// File: rtl/bkpt_addr_match.sv
module bkpt_addr_match
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6,
  parameter int WIN_W  = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [PAGE_W-1:0]   bus_page,
  input  logic                bus_paged,
  input  logic                bus_read,
  input  logic [PAGE_W-1:0]   cmp_ext,
  input  logic [ADDR_W/2-1:0] cmp_hi,
  input  logic [ADDR_W/2-1:0] cmp_lo,
  input  logic                mask_hi,
  input  logic                mask_lo,
  input  logic                dir_en,
  input  logic                dir_read,
  input  logic                dbg_mode,
  output logic                hit
);
  cmp_mode_e mode;
  logic      addr_hit;
  logic      dir_ok;

  bkpt_mask_decode u_dec (
    .mask_hi  (mask_hi),
    .mask_lo  (mask_lo),
    .dbg_mode (dbg_mode),
    .mode     (mode)
  );

  bkpt_addr_cmp #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .WIN_W  (WIN_W)
  ) u_cmp (
    .mode      (mode),
    .bus_addr  (bus_addr),
    .bus_page  (bus_page),
    .bus_paged (bus_paged),
    .cmp_ext   (cmp_ext),
    .cmp_hi    (cmp_hi),
    .cmp_lo    (cmp_lo),
    .addr_hit  (addr_hit)
  );

  bkpt_dir_qual u_dir (
    .dir_en   (dir_en),
    .dir_read (dir_read),
    .bus_read (bus_read),
    .dir_ok   (dir_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= bus_valid & addr_hit & dir_ok;
  end

  // R11: reset clears the pulse
  assert_reset_clears_R11: assert property (@(posedge clk) rst |=> !hit);

  // R11: a pulse needs a valid access in the previous cycle
  assert_hit_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(bus_valid));

  // R9: with direction qualify on, the pulse follows the selected direction
  assert_dir_match_R9: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(dir_en)) |-> ($past(bus_read) == $past(dir_read)));

  // R7: page-only setting never hits a flat access
  assert_page_only_flat_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(mask_hi && mask_lo && !dbg_mode)) |-> $past(bus_paged));

  // R2: a flat access with both masks clear hits only on the exact address
  assert_flat_full_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(!bus_paged && !mask_hi && !mask_lo))
      |-> ($past(bus_addr) == {$past(cmp_hi), $past(cmp_lo)}));
endmodule

// File: tb/tb_bkpt_addr_match.sv
module tb_bkpt_addr_match;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_paged, bus_read;
  logic [15:0] bus_addr;
  logic [5:0]  bus_page;
  logic [5:0]  cmp_ext;
  logic [7:0]  cmp_hi, cmp_lo;
  logic        mask_hi, mask_lo, dir_en, dir_read, dbg_mode;
  logic        hit;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_addr_match dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_page(bus_page), .bus_paged(bus_paged), .bus_read(bus_read),
    .cmp_ext(cmp_ext), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .mask_hi(mask_hi), .mask_lo(mask_lo), .dir_en(dir_en),
    .dir_read(dir_read), .dbg_mode(dbg_mode), .hit(hit)
  );

  // Bench model built from the requirements
  function automatic logic model(logic v, logic [15:0] a, logic [5:0] pg,
                                 logic pd, logic rd);
    logic mh, ml, aok, dok;
    mh = mask_hi & !dbg_mode;
    ml = mask_lo & !dbg_mode;
    if (mh && ml)       aok = pd && (pg == cmp_ext);
    else if (!mh && ml) aok = pd ? (pg == cmp_ext && a[13:8] == cmp_hi[5:0])
                                 : (a[15:8] == cmp_hi);
    else                aok = pd ? ({pg, a[13:0]} == {cmp_ext, cmp_hi[5:0], cmp_lo})
                                 : (a == {cmp_hi, cmp_lo});
    dok = dir_en ? (rd == dir_read) : 1'b1;
    return v && aok && dok;
  endfunction

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: hit=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic set_regs(logic [5:0] e, logic [7:0] h, logic [7:0] l,
                          logic mh, logic ml, logic de, logic dr, logic dm);
    @(negedge clk);
    cmp_ext = e; cmp_hi = h; cmp_lo = l; mask_hi = mh; mask_lo = ml;
    dir_en = de; dir_read = dr; dbg_mode = dm;
  endtask

  // drive one access, check hit one edge later
  task automatic access(string req, logic v, logic [15:0] a, logic [5:0] pg,
                        logic pd, logic rd, logic exp);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_page = pg; bus_paged = pd; bus_read = rd;
    @(posedge clk); #1;
    check(req, hit, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    bus_valid = 1'b1; bus_addr = 16'hC53C; bus_paged = 1'b0;
    @(posedge clk); #1;
    check("R11 reset", hit, 1'b0);
    @(negedge clk); rst = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic t_full;
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    access("R1 paged exact",      1, 16'h853C, 6'h2A, 1, 1, 1'b1);
    access("R1 paged top bits",   1, 16'h453C, 6'h2A, 1, 0, 1'b1);
    access("R1 paged low differs",1, 16'h853D, 6'h2A, 1, 1, 1'b0);
    access("R1 paged page differs",1,16'h853C, 6'h2B, 1, 1, 1'b0);
    access("R3 flat exact",       1, 16'hC53C, 6'h00, 0, 1, 1'b1);
  endtask

  task automatic t_flat;
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    access("R2 ext ignored",      1, 16'hC53C, 6'h11, 0, 0, 1'b1);
    access("R2 top bits count",   1, 16'h853C, 6'h2A, 0, 0, 1'b0);
  endtask

  task automatic t_upper;
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    access("R4 paged low ignored",1, 16'h85FF, 6'h2A, 1, 1, 1'b1);
    access("R4 paged page differs",1,16'h85FF, 6'h2B, 1, 1, 1'b0);
    access("R4 flat low ignored", 1, 16'hC5AA, 6'h00, 0, 1, 1'b1);
    access("R4 flat high differs",1, 16'hC4AA, 6'h00, 0, 1, 1'b0);
  endtask

  task automatic t_illegal;
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    access("R5 flat low compared",1, 16'hC5AA, 6'h00, 0, 1, 1'b0);
    access("R5 flat exact",       1, 16'hC53C, 6'h00, 0, 1, 1'b1);
    access("R5 paged exact",      1, 16'h853C, 6'h2A, 1, 1, 1'b1);
    access("R5 paged high compared",1,16'h003C,6'h2A, 1, 1, 1'b0);
  endtask

  task automatic t_page;
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    access("R6 any addr in page", 1, 16'h1234, 6'h2A, 1, 1, 1'b1);
    access("R6 other page",       1, 16'h1234, 6'h2B, 1, 1, 1'b0);
    access("R7 flat never",       1, 16'hC53C, 6'h2A, 0, 1, 1'b0);
  endtask

  task automatic t_dir;
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    access("R8 read",             1, 16'hC53C, 6'h00, 0, 1, 1'b1);
    access("R8 write",            1, 16'hC53C, 6'h00, 0, 0, 1'b1);
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    access("R9 read sel read",    1, 16'hC53C, 6'h00, 0, 1, 1'b1);
    access("R9 read sel write",   1, 16'hC53C, 6'h00, 0, 0, 1'b0);
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    access("R9 write sel write",  1, 16'hC53C, 6'h00, 0, 0, 1'b1);
    access("R9 write sel read",   1, 16'hC53C, 6'h00, 0, 1, 1'b0);
  endtask

  task automatic t_debug;
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    access("R10 flat full",       1, 16'hC53C, 6'h00, 0, 1, 1'b1);
    access("R10 page-only off",   1, 16'h1234, 6'h2A, 1, 1, 1'b0);
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    access("R10 low not masked",  1, 16'hC5AA, 6'h00, 0, 1, 1'b0);
  endtask

  task automatic t_pulse;
    set_regs(6'h2A, 8'hC5, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    access("R11 invalid no hit",  0, 16'hC53C, 6'h00, 0, 1, 1'b0);
    access("R11 valid hit",       1, 16'hC53C, 6'h00, 0, 1, 1'b1);
    access("R11 single cycle",    0, 16'hC53C, 6'h00, 0, 1, 1'b0);
  endtask

  task automatic t_sweep;
    for (int cfg = 0; cfg < 32; cfg++) begin
      set_regs(6'h2A, 8'hC5, 8'h3C, cfg[0], cfg[1], cfg[2], cfg[3], cfg[4]);
      for (int k = 0; k < 16; k++) begin
        logic [15:0] a;
        logic [5:0]  pg;
        logic        pd, rd, exp;
        a  = {($urandom_range(0,1) != 0) ? 8'hC5 : 8'h05 + 8'(k),
              ($urandom_range(0,1) != 0) ? 8'h3C : 8'(k)};
        if (k[0]) a[15:14] = 2'($urandom_range(0,3));
        pg = ($urandom_range(0,2) != 0) ? 6'h2A : 6'(k);
        pd = k[1];
        rd = k[2];
        exp = model(1'b1, a, pg, pd, rd);
        access("R1-sweep model R4 R5 R6 R7 R9 R10", 1'b1, a, pg, pd, rd, exp);
      end
    end
  endtask

  initial begin
    rst = 1'b1; bus_valid = 0; bus_addr = 0; bus_page = 0; bus_paged = 0;
    bus_read = 0; cmp_ext = 0; cmp_hi = 0; cmp_lo = 0; mask_hi = 0;
    mask_lo = 0; dir_en = 0; dir_read = 0; dbg_mode = 0;
    repeat (2) @(posedge clk);
    t_reset;
    t_full;
    t_flat;
    t_upper;
    t_illegal;
    t_page;
    t_dir;
    t_debug;
    t_pulse;
    t_sweep;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: expired, hit=%b expected=done", hit);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule